// File: doc/BRIEF.md
# Cacheline Descriptor Write-Back Engine

This engine returns one DMA descriptor to memory through a memory port. The descriptor is a single eight-word cacheline of 32-bit words. The port offers a 64-bit write FIFO and a separate address-request channel with an acknowledge. A one-cycle start pulse hands the engine the 256-bit descriptor and the target byte address, and the engine captures both.

The engine first loads the whole cacheline into the port's write FIFO as four 64-bit beats, with every byte lane enabled. It pushes a beat only while the FIFO reports that it has room. Only after the fourth beat has been loaded does it raise the address request, which carries a write direction and the cacheline size code. It holds the request until the port acknowledges it, then drops it and pulses done. Because the request never comes before its data, the memory side can never start a write whose data is not yet in the FIFO.

An address that does not fall on a 32-byte boundary is refused. The refusal is reported on an error flag, and no data moves.

Top module: `desc_wb_engine`

## Requirements
- R1: After a synchronous active-high reset, busy, push, request, done and the error flag are all low, and the engine waits for a start.
- R2: An accepted start produces exactly four FIFO pushes. Beat k (k = 0..3) carries descriptor word 2k on bits 31:0 and word 2k+1 on bits 63:32, where word n is bits 32n+31:32n of the descriptor input. Every pushed beat has byte enables 0xFF.
- R3: A beat is pushed only in a cycle where almost-full is low. While almost-full is high there is no push, and the pending beat is the one that goes out next.
- R4: The address request rises in the cycle after the fourth push, and never before all four beats of the transfer have been pushed.
- R5: While the request is high, the address output equals the captured target address, the size code is 2 and the read-not-write line is 0.
- R6: The request and its address stay unchanged until a cycle in which the acknowledge is high.
- R7: The request is low in the cycle after the acknowledge is sampled. Done is high for exactly that one cycle, and then the engine is idle.
- R8: A start that arrives while busy (pushing, requesting or signalling done) is ignored. Its descriptor and address are never written.
- R9: A start in idle whose address has any of bits 4:0 set raises the error flag, and no push or request follows. The flag stays high until the next start with an aligned address, which clears it.
- R10: The descriptor and address are captured at the accepted start. Later changes on those inputs do not alter the pushed data or the requested address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| desc_i | input | 256 | Descriptor line, word 0 in the low bits |
| addr_i | input | 32 | Target byte address |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| align_err_o | output | 1 | Last start was refused as unaligned |
| wr_data_o | output | 64 | Write FIFO data beat |
| wr_be_o | output | 8 | Write FIFO byte enables |
| wr_push_o | output | 1 | Write FIFO push strobe |
| wr_afull_i | input | 1 | Write FIFO almost full |
| req_addr_o | output | 32 | Request address |
| req_o | output | 1 | Address request |
| req_rnw_o | output | 1 | Read-not-write, 0 for this write |
| req_size_o | output | 4 | Transfer size code |
| req_ack_i | input | 1 | Address acknowledge |

## Verification
The bench holds almost-full high across beat boundaries and on the very first push cycle. A design that counted beats regardless of FIFO space would skip or repeat a beat there, and one that raised the request early would show it before the fourth push. Acknowledge comes with zero and several cycles of latency, and it also arrives spuriously while the engine is idle or still pushing. A design that latched an early acknowledge, or dropped the request before one arrived, would end the transfer at the wrong time. Further starts are issued while the engine is busy, and the descriptor and address inputs are changed after acceptance, so a design that recaptured them would push wrong data. An unaligned start followed by an aligned one checks that the error flag is raised, moves no data and is then cleared.

// File: rtl/desc_wb_pkg.sv
package desc_wb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_REQ  = 2'd2,
        ST_DONE = 2'd3
    } wb_state_e;

endpackage

// File: rtl/desc_wb_align_chk.sv
module desc_wb_align_chk #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              aligned_o
);
    // low address bits select a byte inside the line; all must be zero
    assign aligned_o = (addr_i[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/desc_wb_beat_mux.sv
module desc_wb_beat_mux #(
    parameter int LINE_W = 256,
    parameter int BEAT_W = 64,
    parameter int IDX_W  = 2
) (
    input  logic [LINE_W-1:0] line_i,
    input  logic [IDX_W-1:0]  sel_i,
    output logic [BEAT_W-1:0] beat_o
);
    localparam int BEATS = LINE_W / BEAT_W;

    logic [BEAT_W-1:0] lane [BEATS];

    for (genvar g = 0; g < BEATS; g++) begin : g_lane
        assign lane[g] = line_i[g*BEAT_W +: BEAT_W];
    end

    assign beat_o = lane[sel_i];
endmodule

// File: rtl/desc_wb_engine.sv
module desc_wb_engine
    import desc_wb_pkg::*;
#(
    parameter int         ADDR_W     = 32,
    parameter int         WORD_W     = 32,
    parameter int         LINE_WORDS = 8,
    parameter int         BEAT_W     = 64,
    parameter logic [3:0] SIZE_CODE  = 4'd2
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    input  logic [LINE_WORDS*WORD_W-1:0]   desc_i,
    input  logic [ADDR_W-1:0]              addr_i,
    output logic                           busy_o,
    output logic                           done_o,
    output logic                           align_err_o,
    output logic [BEAT_W-1:0]              wr_data_o,
    output logic [BEAT_W/8-1:0]            wr_be_o,
    output logic                           wr_push_o,
    input  logic                           wr_afull_i,
    output logic [ADDR_W-1:0]              req_addr_o,
    output logic                           req_o,
    output logic                           req_rnw_o,
    output logic [3:0]                     req_size_o,
    input  logic                           req_ack_i
);
    localparam int LINE_W     = LINE_WORDS * WORD_W;
    localparam int BEATS      = LINE_W / BEAT_W;
    localparam int IDX_W      = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam int BE_W       = BEAT_W / 8;
    localparam int ALIGN_BITS = $clog2(LINE_W / 8);
    localparam int CNT_W      = $clog2(BEATS + 1);
    localparam logic [IDX_W-1:0] BEAT_LAST = IDX_W'(BEATS - 1);
    localparam logic [CNT_W-1:0] BEAT_CNT  = CNT_W'(BEATS);

    typedef struct packed {
        wb_state_e          st;
        logic [IDX_W-1:0]   beat;
        logic [ADDR_W-1:0]  addr;
        logic [LINE_W-1:0]  line;
        logic               err;
    } regs_t;

    regs_t r_d, r_q;
    logic  aligned;
    logic  push_d;

    desc_wb_align_chk #(.ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_align (
        .addr_i    (addr_i),
        .aligned_o (aligned)
    );

    desc_wb_beat_mux #(.LINE_W(LINE_W), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_mux (
        .line_i (r_q.line),
        .sel_i  (r_q.beat),
        .beat_o (wr_data_o)
    );

    always_comb begin
        r_d    = r_q;
        push_d = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    if (aligned) begin
                        r_d.st   = ST_PUSH;
                        r_d.beat = '0;
                        r_d.addr = addr_i;
                        r_d.line = desc_i;
                        r_d.err  = 1'b0;
                    end else begin
                        r_d.err  = 1'b1;
                    end
                end
            end
            ST_PUSH: begin
                if (!wr_afull_i) begin
                    push_d = 1'b1;
                    if (r_q.beat == BEAT_LAST) r_d.st   = ST_REQ;
                    else                       r_d.beat = r_q.beat + 1'b1;
                end
            end
            ST_REQ: begin
                if (req_ack_i) r_d.st = ST_DONE;
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign busy_o      = (r_q.st != ST_IDLE);
    assign done_o      = (r_q.st == ST_DONE);
    assign align_err_o = r_q.err;
    assign wr_push_o   = push_d;
    assign wr_be_o     = {BE_W{1'b1}};
    assign req_o       = (r_q.st == ST_REQ);
    assign req_addr_o  = r_q.addr;
    assign req_rnw_o   = !req_o;
    assign req_size_o  = req_o ? SIZE_CODE : 4'd0;

    // ---------------- assertions ----------------
    logic [CNT_W-1:0] chk_push_q;
    always_ff @(posedge clk) begin
        if (rst)                                      chk_push_q <= '0;
        else if (!busy_o && start_i && aligned)       chk_push_q <= '0;
        else if (wr_push_o)                           chk_push_q <= chk_push_q + 1'b1;
    end

    assert_req_after_data_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(req_o) |-> (chk_push_q == BEAT_CNT));

    assert_push_not_during_req_R3: assert property (@(posedge clk) disable iff (rst)
        wr_push_o |-> (busy_o && !req_o && !done_o));

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (req_o && !req_ack_i) |=> (req_o && $stable(req_addr_o)));

    assert_req_drop_done_R7: assert property (@(posedge clk) disable iff (rst)
        (req_o && req_ack_i) |=> (!req_o && done_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> (!done_o && !busy_o));

    assert_req_fields_R5: assert property (@(posedge clk) disable iff (rst)
        req_o |-> (req_size_o == SIZE_CODE && !req_rnw_o));

    assert_unaligned_refused_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && addr_i[ALIGN_BITS-1:0] != '0) |=> (align_err_o && !busy_o));
endmodule

// File: tb/desc_wb_engine_tb_top.sv
module desc_wb_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst;
    logic         start_i;
    logic [255:0] desc_i;
    logic [31:0]  addr_i;
    logic         busy_o, done_o, align_err_o;
    logic [63:0]  wr_data_o;
    logic [7:0]   wr_be_o;
    logic         wr_push_o;
    logic         wr_afull_i;
    logic [31:0]  req_addr_o;
    logic         req_o, req_rnw_o;
    logic [3:0]   req_size_o;
    logic         req_ack_i;

    always #2 clk = ~clk;   // 250 MHz

    desc_wb_engine dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .desc_i(desc_i), .addr_i(addr_i),
        .busy_o(busy_o), .done_o(done_o), .align_err_o(align_err_o),
        .wr_data_o(wr_data_o), .wr_be_o(wr_be_o), .wr_push_o(wr_push_o),
        .wr_afull_i(wr_afull_i), .req_addr_o(req_addr_o), .req_o(req_o),
        .req_rnw_o(req_rnw_o), .req_size_o(req_size_o), .req_ack_i(req_ack_i)
    );

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done_run = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_run) begin
            done_run = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // ---------------- reference model ----------------
    int           m_phase = 0;   // 0 idle, 1 loading beats, 2 requesting, 3 done
    int           m_beat  = 0;
    bit           m_err   = 0;
    logic [255:0] m_line  = '0;
    logic [31:0]  m_addr  = '0;
    int           m_pushes = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_phase = 0; m_err = 0;
        end else begin
            case (m_phase)
                0: if (start_i) begin
                       if (addr_i[4:0] != 5'd0) m_err = 1;
                       else begin
                           m_err = 0; m_line = desc_i; m_addr = addr_i;
                           m_beat = 0; m_phase = 1; m_pushes = 0;
                       end
                   end
                1: if (!wr_afull_i) begin
                       m_pushes++;
                       if (m_beat == 3) m_phase = 2; else m_beat++;
                   end
                2: if (req_ack_i) m_phase = 3;
                default: m_phase = 0;
            endcase
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst && cycles > 0) begin
            bit ep;
            ep = (m_phase == 1) && !wr_afull_i;
            chk(busy_o == (m_phase != 0), "R8", "busy", 64'(busy_o), 64'(m_phase != 0));
            chk(wr_push_o == ep, "R3", "push", 64'(wr_push_o), 64'(ep));
            if (ep) begin
                chk(wr_data_o == m_line[m_beat*64 +: 64], "R2", "beat data", wr_data_o, m_line[m_beat*64 +: 64]);
                chk(wr_be_o == 8'hFF, "R2", "byte enables", 64'(wr_be_o), 64'hFF);
            end
            chk(req_o == (m_phase == 2), "R4", "request", 64'(req_o), 64'(m_phase == 2));
            if (m_phase == 2) begin
                chk(req_addr_o == m_addr, "R10", "request address", 64'(req_addr_o), 64'(m_addr));
                chk(req_size_o == 4'd2, "R5", "size", 64'(req_size_o), 64'd2);
                chk(req_rnw_o == 1'b0, "R5", "rnw", 64'(req_rnw_o), 64'd0);
            end
            chk(done_o == (m_phase == 3), "R7", "done", 64'(done_o), 64'(m_phase == 3));
            chk(align_err_o == m_err, "R9", "align error", 64'(align_err_o), 64'(m_err));
        end
        if (cycles > 100000) begin
            chk(0, "R1", "watchdog", 64'(cycles), 64'd100000);
            finish_run();
        end
    end

    // ---------------- port responders ----------------
    logic [15:0] afull_pat = 16'h0000;
    int          afull_idx = 0;
    int          ack_lat   = 0;
    bit          ack_noise = 0;
    int          ack_wait  = 0;

    always @(posedge clk) begin
        #1;
        wr_afull_i = afull_pat[afull_idx % 16];
        afull_idx++;
        if (req_o) begin
            req_ack_i = (ack_wait >= ack_lat);
            ack_wait++;
        end else begin
            req_ack_i = ack_noise;
            ack_wait  = 0;
        end
    end

    function automatic logic [255:0] mk_line(input int seed);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = 32'(seed * 32'h01010101 + w * 32'h11111111);
        return l;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic start_xfer(input logic [31:0] a, input int seed);
        addr_i = a; desc_i = mk_line(seed); start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) tick();
        tick();
    endtask

    initial begin
        rst = 1'b1; start_i = 1'b0; desc_i = '0; addr_i = '0;
        wr_afull_i = 1'b0; req_ack_i = 1'b0;
        repeat (3) tick();
        // R1: reset state
        chk(!busy_o && !wr_push_o && !req_o && !done_o && !align_err_o, "R1", "reset outputs",
            {59'd0, busy_o, wr_push_o, req_o, done_o, align_err_o}, 64'd0);
        rst = 1'b0;
        tick();

        // plain transfer, ack after 3 cycles
        ack_lat = 3;
        start_xfer(32'h0000_1000, 1);
        wait_idle();

        // back-pressure patterns, spurious ack while idle/pushing, immediate ack
        afull_pat = 16'b1011_0010_1100_1101; ack_lat = 0; ack_noise = 1;
        start_xfer(32'h0000_2020, 2);
        // R10: change inputs after acceptance
        desc_i = mk_line(99); addr_i = 32'hFFFF_FFE0;
        // R8: start while busy is ignored
        start_xfer(32'h0000_3000, 3);
        start_xfer(32'h0000_3040, 4);
        wait_idle();
        ack_noise = 0;

        afull_pat = 16'hFFF0; ack_lat = 5;
        start_xfer(32'hABCD_EF00, 5);
        // R6: request held across delayed ack - checked each cycle by the model
        wait_idle();

        // R9: unaligned start refused, then cleared by aligned start
        afull_pat = 16'h0000; ack_lat = 1;
        start_xfer(32'h0000_4004, 6);
        repeat (3) tick();
        chk(!busy_o && align_err_o, "R9", "unaligned refused", {62'd0, busy_o, align_err_o}, 64'd1);
        start_xfer(32'h0000_4010, 7);
        repeat (2) tick();
        start_xfer(32'h0000_4000, 8);
        wait_idle();
        chk(!align_err_o, "R9", "flag cleared", 64'(align_err_o), 64'd0);

        // start during done cycle ignored (R8)
        ack_lat = 0;
        start_xfer(32'h0000_5000, 9);
        while (!req_o) tick();
        tick();
        start_xfer(32'h0000_6000, 10);
        repeat (4) tick();
        chk(!busy_o, "R8", "start in done ignored", 64'(busy_o), 64'd0);

        // reset mid-transfer (R1)
        afull_pat = 16'h00F0;
        start_xfer(32'h0000_7000, 11);
        tick();
        rst = 1'b1; tick(); rst = 1'b0;
        chk(!busy_o && !wr_push_o && !req_o, "R1", "reset mid-transfer",
            {61'd0, busy_o, wr_push_o, req_o}, 64'd0);
        afull_pat = 16'h0000;
        start_xfer(32'h0000_8000, 12);
        wait_idle();
        chk(m_pushes == 4, "R2", "push count", 64'(m_pushes), 64'd4);

        repeat (3) tick();
        finish_run();
    end
endmodule